// File: doc/BRIEF.md
# Programmable RGB Display Timing Generator

This block produces the timing for a parallel RGB panel: vertical sync, horizontal sync, an optional data-enable signal, and a strobe marking the pixel slots that carry picture data. It advances one position per pixel-clock enable. A position counter runs across each line, and a frame counter runs across each vertical period. Decoders against the programmed widths and windows drive the outputs. A polarity bit sets the active level of each sync output.

The vertical period and the VSYNC pulse width each have their own unit bit. One unit is the pixel clock and the other is the whole line. An optional half-line extension adds half a line to every vertical period, which supports interlaced fields. A placement bit selects one of two policies. With the bit clear, the line counter runs on across the field boundary, so fields alternately end mid-line and begin mid-line. With the bit set, the line counter restarts at every field start, so every field ends on half a line.

All configuration is captured at the start of each frame. A change made mid-frame therefore only takes effect on the next frame. A status output flags a VSYNC width in clock units that is not shorter than one line.

Top module: `rgb_timing_gen`

## Requirements
- R1: While `rst` is sampled high, all counters clear and the block stops running. From the following cycle, `vsync` is `~vs_pol` and `hsync` is `~hs_pol`. `de` is `~de_pol` when `de_gen` is 1 and 0 otherwise. These levels come from the live inputs. `frame_start`, `line_start`, `pix_strobe`, `cfg_err` and `launch_on_rise` are all 0.
- R2: A line lasts `h_total` enabled clocks, with positions 0 to `h_total`-1. `hsync` is at level `hs_pol` at positions below `hs_len` and at `~hs_pol` elsewhere, so it is active low by default. `line_start` is 1 when the position is 0 and `ce` is 1.
- R3: A position is active when it is at least `act_begin` and below `act_begin+act_len`. Active positions stop at the end of the line. `pix_strobe` is active AND `ce`. When `de_gen` is 1, `de` is `de_pol` at active positions and `~de_pol` elsewhere. When `de_gen` is 0, `de` stays 0.
- R4: `vsync` is at level `vs_pol` during the first VSYNC-width units of each frame and at `~vs_pol` for the rest of the frame.
- R5: With `v_in_lines`=0 the base vertical period is `v_total` clocks. With `v_in_lines`=1 it is `v_total`×`h_total` clocks.
- R6: With `vs_in_lines`=0 the VSYNC width is `vs_len` clocks. With `vs_in_lines`=1 it is `vs_len`×`h_total` clocks.
- R7: While running, `cfg_err` is 1 exactly when the captured configuration has `vs_in_lines`=0 and `vs_len` ≥ `h_total`.
- R8: With `half_line_en`=1 the frame lasts the base period plus floor(`h_total`/2) clocks.
- R9: At a frame start, the line position restarts at 0 unless `half_line_en`=1 and `half_line_all`=0. In that one case the position simply continues, so alternate fields start mid-line.
- R10: `frame_start` is 1 for exactly the first enabled clock of each frame, which is frame position 0 with `ce`=1.
- R11: The configuration is captured at the first enabled clock after reset and at each frame wrap. Changes at any other time do not affect the current frame.
- R12: `launch_on_rise` equals the captured `clk_pol`. A value of 0 means data launches on the falling pixel-clock edge and is captured on the rising edge. A value of 1 swaps both edges.
- R13: While `ce` is 0 the counters hold, and `frame_start`, `line_start` and `pix_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Pixel clock enable |
| h_total | input | HW | Line length in clocks |
| hs_len | input | HW | HSYNC width in clocks |
| act_begin | input | HW | First active position in a line |
| act_len | input | HW | Number of active positions |
| v_total | input | VW | Vertical period count |
| vs_len | input | VW | VSYNC width count |
| v_in_lines | input | 1 | Vertical period unit: 0 clocks, 1 lines |
| vs_in_lines | input | 1 | VSYNC width unit: 0 clocks, 1 lines |
| half_line_en | input | 1 | Add half a line to each frame |
| half_line_all | input | 1 | Half-line placement policy |
| vs_pol | input | 1 | VSYNC active level |
| hs_pol | input | 1 | HSYNC active level |
| de_pol | input | 1 | Data-enable active level |
| de_gen | input | 1 | Generate data enable |
| clk_pol | input | 1 | Pixel clock edge polarity |
| vsync | output | 1 | Polarized vertical sync |
| hsync | output | 1 | Polarized horizontal sync |
| de | output | 1 | Polarized data enable |
| frame_start | output | 1 | First clock of a frame |
| line_start | output | 1 | First clock of a line |
| pix_strobe | output | 1 | Active pixel slot |
| cfg_err | output | 1 | VSYNC clock width not shorter than a line |
| launch_on_rise | output | 1 | Captured clock polarity |

## Verification
The properties assume that the configuration is sane: `h_total` is at least 2 and the resulting frame length is at least 1. Reset must be held high from time zero. The stimulus keeps every programmed length well inside these limits. It uses short lines and frames, so that several wraps, both half-line policies, odd line lengths, an active window that runs past the end of the line, and an oversized clock-unit VSYNC width all occur within a few hundred cycles. Clock-enable gaps are applied on a fixed pattern, and every configuration change is made on a falling edge so that capture timing is unambiguous.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;

   // Mode and polarity bits captured together at frame start
   typedef struct packed {
      logic vs_pol;
      logic hs_pol;
      logic de_pol;
      logic de_gen;
      logic clk_pol;
      logic v_lines;
      logic w_lines;
      logic half_en;
      logic half_all;
   } tg_flags_t;

   // Whether the line position is forced to zero when a frame with these flags begins
   function automatic logic line_restarts(tg_flags_t f);
      return !(f.half_en && !f.half_all);
   endfunction

endpackage

// File: rtl/rgb_tg_cfg_reg.sv
module rgb_tg_cfg_reg
   import rgb_tg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [HW-1:0] h_total_i,
   input  logic [HW-1:0] hs_len_i,
   input  logic [HW-1:0] act_begin_i,
   input  logic [HW-1:0] act_len_i,
   input  logic [VW-1:0] v_total_i,
   input  logic [VW-1:0] vs_len_i,
   input  tg_flags_t     flags_i,
   output logic [HW-1:0] h_total_o,
   output logic [HW-1:0] hs_len_o,
   output logic [HW-1:0] act_begin_o,
   output logic [HW-1:0] act_len_o,
   output logic [VW-1:0] v_total_o,
   output logic [VW-1:0] vs_len_o,
   output tg_flags_t     flags_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         h_total_o   <= '0;
         hs_len_o    <= '0;
         act_begin_o <= '0;
         act_len_o   <= '0;
         v_total_o   <= '0;
         vs_len_o    <= '0;
         flags_o     <= '0;
      end else if (load) begin
         h_total_o   <= h_total_i;
         hs_len_o    <= hs_len_i;
         act_begin_o <= act_begin_i;
         act_len_o   <= act_len_i;
         v_total_o   <= v_total_i;
         vs_len_o    <= vs_len_i;
         flags_o     <= flags_i;
      end
   end

endmodule

// File: rtl/rgb_tg_vtimer.sv
module rgb_tg_vtimer
   import rgb_tg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11,
   localparam int FW = HW + VW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic [HW-1:0] h_total,
   input  logic [VW-1:0] v_total,
   input  logic [VW-1:0] vs_len,
   input  tg_flags_t     flags,
   output logic          run,
   output logic          load,
   output logic          frame_first,
   output logic          vs_act,
   output logic          cfg_err
);

   logic [FW-1:0] fcnt;
   logic [FW-1:0] h_ext, v_ext, w_ext;
   logic [FW-1:0] base_len, half_len, frame_len, vs_span;
   logic          last_pos;

   always_comb begin
      h_ext     = {{(FW-HW){1'b0}}, h_total};
      v_ext     = {{(FW-VW){1'b0}}, v_total};
      w_ext     = {{(FW-VW){1'b0}}, vs_len};
      base_len  = flags.v_lines ? (v_ext * h_ext) : v_ext;
      half_len  = flags.half_en ? (h_ext >> 1) : '0;
      frame_len = base_len + half_len;
      vs_span   = flags.w_lines ? (w_ext * h_ext) : w_ext;
      last_pos  = (fcnt + 1'b1) >= frame_len;
   end

   // configuration capture: first enabled clock, then every frame wrap
   assign load        = ce && (!run || last_pos);
   assign frame_first = run && (fcnt == '0);
   assign vs_act      = run && (fcnt < vs_span);
   assign cfg_err     = run && !flags.w_lines && (w_ext >= h_ext);

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= 1'b0;
         fcnt <= '0;
      end else if (ce) begin
         run <= 1'b1;
         if (load) fcnt <= '0;
         else      fcnt <= fcnt + 1'b1;
      end
   end

endmodule

// File: rtl/rgb_tg_htimer.sv
module rgb_tg_htimer #(
   parameter int HW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic          run,
   input  logic          load,
   input  logic          restart_nx,
   input  logic [HW-1:0] h_total,
   input  logic [HW-1:0] hs_len,
   input  logic [HW-1:0] act_begin,
   input  logic [HW-1:0] act_len,
   output logic          line_first,
   output logic          hs_act,
   output logic          act
);

   logic [HW-1:0] hcnt;
   logic [HW-1:0] hcnt_nx;
   logic [HW:0]   act_end;

   always_comb begin
      if (({1'b0, hcnt} + 1'b1) >= {1'b0, h_total}) hcnt_nx = '0;
      else                                          hcnt_nx = hcnt + 1'b1;
      act_end = {1'b0, act_begin} + {1'b0, act_len};
   end

   assign line_first = run && (hcnt == '0);
   assign hs_act     = run && (hcnt < hs_len);
   assign act        = run && (hcnt >= act_begin) && ({1'b0, hcnt} < act_end);

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt <= '0;
      end else if (ce) begin
         if (load && (!run || restart_nx)) hcnt <= '0;
         else if (run)                     hcnt <= hcnt_nx;
      end
   end

endmodule

// File: rtl/rgb_tg_drive.sv
module rgb_tg_drive
   import rgb_tg_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      ce,
   input  logic      run,
   input  tg_flags_t flags_live,
   input  tg_flags_t flags_cap,
   input  logic      frame_first,
   input  logic      line_first,
   input  logic      vs_act,
   input  logic      hs_act,
   input  logic      act,
   input  logic      err_in,
   output logic      vsync,
   output logic      hsync,
   output logic      de,
   output logic      frame_start,
   output logic      line_start,
   output logic      pix_strobe,
   output logic      cfg_err,
   output logic      launch_on_rise
);

   tg_flags_t pol;
   logic vs_c, hs_c, de_c, fs_c, ls_c, ps_c;

   always_comb begin
      pol  = run ? flags_cap : flags_live;
      vs_c = vs_act ? pol.vs_pol : ~pol.vs_pol;
      hs_c = hs_act ? pol.hs_pol : ~pol.hs_pol;
      de_c = pol.de_gen && (act ? pol.de_pol : ~pol.de_pol);
      fs_c = frame_first && ce;
      ls_c = line_first && ce;
      ps_c = act && ce;
   end

   assign launch_on_rise = flags_cap.clk_pol;
   assign cfg_err        = err_in;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               vsync       <= ~flags_live.vs_pol;
               hsync       <= ~flags_live.hs_pol;
               de          <= flags_live.de_gen && ~flags_live.de_pol;
               frame_start <= 1'b0;
               line_start  <= 1'b0;
               pix_strobe  <= 1'b0;
            end else begin
               vsync       <= vs_c;
               hsync       <= hs_c;
               de          <= de_c;
               frame_start <= fs_c;
               line_start  <= ls_c;
               pix_strobe  <= ps_c;
            end
         end
      end else begin : g_comb
         assign vsync       = vs_c;
         assign hsync       = hs_c;
         assign de          = de_c;
         assign frame_start = fs_c;
         assign line_start  = ls_c;
         assign pix_strobe  = ps_c;
      end
   endgenerate

endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen
   import rgb_tg_pkg::*;
#(
   parameter int HW      = 12,
   parameter int VW      = 11,
   parameter bit OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ce,
   input  logic [HW-1:0] h_total,
   input  logic [HW-1:0] hs_len,
   input  logic [HW-1:0] act_begin,
   input  logic [HW-1:0] act_len,
   input  logic [VW-1:0] v_total,
   input  logic [VW-1:0] vs_len,
   input  logic          v_in_lines,
   input  logic          vs_in_lines,
   input  logic          half_line_en,
   input  logic          half_line_all,
   input  logic          vs_pol,
   input  logic          hs_pol,
   input  logic          de_pol,
   input  logic          de_gen,
   input  logic          clk_pol,
   output logic          vsync,
   output logic          hsync,
   output logic          de,
   output logic          frame_start,
   output logic          line_start,
   output logic          pix_strobe,
   output logic          cfg_err,
   output logic          launch_on_rise
);

   initial begin
      if (HW < 2)  $error("rgb_timing_gen: HW must be at least 2");
      if (VW < 1)  $error("rgb_timing_gen: VW must be at least 1");
      if (HW + VW > 40) $error("rgb_timing_gen: frame counter too wide");
   end

   tg_flags_t     flags_live, flags_cap;
   logic [HW-1:0] h_total_c, hs_len_c, act_begin_c, act_len_c;
   logic [VW-1:0] v_total_c, vs_len_c;
   logic          run, load, frame_first, line_first;
   logic          vs_act, hs_act, act, err_raw, restart_nx;

   always_comb begin
      flags_live.vs_pol   = vs_pol;
      flags_live.hs_pol   = hs_pol;
      flags_live.de_pol   = de_pol;
      flags_live.de_gen   = de_gen;
      flags_live.clk_pol  = clk_pol;
      flags_live.v_lines  = v_in_lines;
      flags_live.w_lines  = vs_in_lines;
      flags_live.half_en  = half_line_en;
      flags_live.half_all = half_line_all;
      restart_nx          = line_restarts(flags_live);
   end

   rgb_tg_cfg_reg #(.HW(HW), .VW(VW)) i_cfg (
      .clk(clk), .rst(rst), .load(load),
      .h_total_i(h_total), .hs_len_i(hs_len), .act_begin_i(act_begin),
      .act_len_i(act_len), .v_total_i(v_total), .vs_len_i(vs_len),
      .flags_i(flags_live),
      .h_total_o(h_total_c), .hs_len_o(hs_len_c), .act_begin_o(act_begin_c),
      .act_len_o(act_len_c), .v_total_o(v_total_c), .vs_len_o(vs_len_c),
      .flags_o(flags_cap)
   );

   rgb_tg_vtimer #(.HW(HW), .VW(VW)) i_vt (
      .clk(clk), .rst(rst), .ce(ce),
      .h_total(h_total_c), .v_total(v_total_c), .vs_len(vs_len_c),
      .flags(flags_cap),
      .run(run), .load(load), .frame_first(frame_first),
      .vs_act(vs_act), .cfg_err(err_raw)
   );

   rgb_tg_htimer #(.HW(HW)) i_ht (
      .clk(clk), .rst(rst), .ce(ce), .run(run), .load(load),
      .restart_nx(restart_nx),
      .h_total(h_total_c), .hs_len(hs_len_c),
      .act_begin(act_begin_c), .act_len(act_len_c),
      .line_first(line_first), .hs_act(hs_act), .act(act)
   );

   rgb_tg_drive #(.OUT_REG(OUT_REG)) i_drv (
      .clk(clk), .rst(rst), .ce(ce), .run(run),
      .flags_live(flags_live), .flags_cap(flags_cap),
      .frame_first(frame_first), .line_first(line_first),
      .vs_act(vs_act), .hs_act(hs_act), .act(act), .err_in(err_raw),
      .vsync(vsync), .hsync(hsync), .de(de),
      .frame_start(frame_start), .line_start(line_start),
      .pix_strobe(pix_strobe), .cfg_err(cfg_err),
      .launch_on_rise(launch_on_rise)
   );

endmodule

// File: rtl/rgb_tg_chk.sv
module rgb_tg_chk (
   input logic clk,
   input logic rst,
   input logic ce,
   input logic load,
   input logic half_en_c,
   input logic half_all_c,
   input logic frame_start,
   input logic line_start,
   input logic pix_strobe,
   input logic cfg_err
);

   // R13
   pulses_need_ce_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_start || line_start || pix_strobe) |-> ce);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!frame_start && !line_start && !pix_strobe));

   // R7
   err_held_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cfg_err));

   // R9
   frame_line_align_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_start && !(half_en_c && !half_all_c)) |-> line_start);

   // R10
   frame_pulse_ce_chk: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (ce && load == 1'b0) || (ce && load));

endmodule

bind rgb_timing_gen rgb_tg_chk i_chk (
   .clk(clk), .rst(rst), .ce(ce), .load(load),
   .half_en_c(flags_cap.half_en), .half_all_c(flags_cap.half_all),
   .frame_start(frame_start), .line_start(line_start),
   .pix_strobe(pix_strobe), .cfg_err(cfg_err)
);

// File: tb/test_rgb_timing_gen.sv
module test_rgb_timing_gen;

   localparam int HW = 12;
   localparam int VW = 11;

   typedef struct packed {
      logic [11:0] h, hs, ab, al;
      logic [10:0] v, vs;
      logic pl, wl, he, ha, vp, hp, ep, eg, cp;
   } tcfg_t;

   typedef struct packed {
      tcfg_t       c;
      logic        gaps;
      logic [9:0]  ncyc;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{'{12'd10,12'd2,12'd3,12'd5, 11'd4,11'd1,  1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0}, 1'b0, 10'd130},
      '{'{12'd8, 12'd3,12'd2,12'd4, 11'd30,11'd5, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1,1'b1}, 1'b0, 10'd100},
      '{'{12'd10,12'd2,12'd3,12'd5, 11'd3,11'd1,  1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0}, 1'b0, 10'd120},
      '{'{12'd9, 12'd2,12'd2,12'd4, 11'd3,11'd2,  1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0}, 1'b0, 10'd130},
      '{'{12'd10,12'd2,12'd3,12'd5, 11'd5,11'd12, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0}, 1'b0, 10'd110},
      '{'{12'd6, 12'd1,12'd1,12'd3, 11'd2,11'd1,  1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0}, 1'b1, 10'd90},
      '{'{12'd8, 12'd2,12'd4,12'd10,11'd3,11'd1,  1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b0}, 1'b0, 10'd60},
      '{'{12'd5, 12'd1,12'd1,12'd2, 11'd7,11'd3,  1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0}, 1'b0, 10'd40}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ce  = 1'b0;
   tcfg_t cur;

   logic vsync, hsync, de, frame_start, line_start, pix_strobe, cfg_err, launch_on_rise;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;

   // bench reference state
   logic  mrun = 1'b0;
   tcfg_t mc = '0;
   int    fpos = 0;
   int    hpos = 0;

   always #10 clk = ~clk;

   rgb_timing_gen #(.HW(HW), .VW(VW)) i_rgb_timing_gen (
      .clk(clk), .rst(rst), .ce(ce),
      .h_total(cur.h), .hs_len(cur.hs), .act_begin(cur.ab), .act_len(cur.al),
      .v_total(cur.v), .vs_len(cur.vs),
      .v_in_lines(cur.pl), .vs_in_lines(cur.wl),
      .half_line_en(cur.he), .half_line_all(cur.ha),
      .vs_pol(cur.vp), .hs_pol(cur.hp), .de_pol(cur.ep), .de_gen(cur.eg),
      .clk_pol(cur.cp),
      .vsync(vsync), .hsync(hsync), .de(de),
      .frame_start(frame_start), .line_start(line_start),
      .pix_strobe(pix_strobe), .cfg_err(cfg_err),
      .launch_on_rise(launch_on_rise)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int flen(input tcfg_t c);
      int b;
      b = c.pl ? int'(c.v) * int'(c.h) : int'(c.v);   // R5
      if (c.he) b = b + int'(c.h) / 2;                 // R8
      return b;
   endfunction

   function automatic int vspan(input tcfg_t c);
      return c.wl ? int'(c.vs) * int'(c.h) : int'(c.vs);  // R6
   endfunction

   // one clock: drive on the falling edge, compare, then step the reference
   task automatic step(input logic c, input logic r);
      logic a, e_vs, e_hs, e_de, e_fs, e_ls, e_ps, e_er;
      @(negedge clk);
      ce  = c;
      rst = r;
      #1;
      if (!mrun) begin
         e_vs = ~cur.vp; e_hs = ~cur.hp; e_de = cur.eg & ~cur.ep;
         e_fs = 1'b0; e_ls = 1'b0; e_ps = 1'b0; e_er = 1'b0;
      end else begin
         a    = (hpos >= int'(mc.ab)) && (hpos < int'(mc.ab) + int'(mc.al));
         e_vs = (fpos < vspan(mc)) ? mc.vp : ~mc.vp;
         e_hs = (hpos < int'(mc.hs)) ? mc.hp : ~mc.hp;
         e_de = mc.eg & (a ? mc.ep : ~mc.ep);
         e_fs = c && (fpos == 0);
         e_ls = c && (hpos == 0);
         e_ps = c && a;
         e_er = !mc.wl && (int'(mc.vs) >= int'(mc.h));
      end
      chk("R4 vsync", vsync, e_vs);
      chk("R2 hsync", hsync, e_hs);
      chk("R3 de", de, e_de);
      chk("R10 frame_start", frame_start, e_fs);
      chk("R2 line_start", line_start, e_ls);
      chk("R3/R13 pix_strobe", pix_strobe, e_ps);
      chk("R7 cfg_err", cfg_err, e_er);
      chk("R12 launch_on_rise", launch_on_rise, mc.cp);
      if (r) begin
         mrun = 1'b0; mc = '0; fpos = 0; hpos = 0;
      end else if (c) begin
         if (!mrun) begin
            mrun = 1'b1; mc = cur; fpos = 0; hpos = 0;            // R11
         end else if (fpos + 1 >= flen(mc)) begin
            hpos = (hpos + 1 >= int'(mc.h)) ? 0 : hpos + 1;
            mc   = cur;                                           // R11
            if (!(mc.he && !mc.ha)) hpos = 0;                     // R9
            fpos = 0;
         end else begin
            fpos = fpos + 1;
            hpos = (hpos + 1 >= int'(mc.h)) ? 0 : hpos + 1;
         end
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      cur = VECS[0].c;
      // R1: reset state with default polarities
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 R13
      for (int i = 0; i < NV; i++) begin
         cur = VECS[i].c;
         step(1'b1, 1'b1);
         step(1'b1, 1'b1);
         for (int k = 0; k < int'(VECS[i].ncyc); k++)
            step(VECS[i].gaps ? logic'((k % 3) != 1) : 1'b1, 1'b0);
      end
      // R1: reset mid-frame with inverted polarities, then hold ce low (R13)
      cur = VECS[1].c;
      for (int k = 0; k < 12; k++) step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      for (int k = 0; k < 5; k++) step(1'b0, 1'b0);
      // R11: mid-frame change to the line length applies at the next frame
      cur = VECS[0].c;
      for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
      cur.h  = 12'd12;
      cur.hs = 12'd4;
      for (int k = 0; k < 110; k++) step(1'b1, 1'b0);
      // R7: error clears once a legal configuration is captured
      cur = VECS[4].c;
      step(1'b1, 1'b1);
      for (int k = 0; k < 60; k++) step(1'b1, 1'b0);
      cur.vs = 11'd3;
      for (int k = 0; k < 60; k++) step(1'b1, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule